// File: doc/BRIEF.md
# Multi-Step Power Rail Sequencer

This block turns a bank of point-of-load converter enables on and off in a configured order. Six sequencing steps each carry a mask of the rails they switch and a delay counted in slow ticks. On the way up, each step adds its rails to the enabled set and waits its delay. The sequencer then requires every rail switched on so far to report good before it moves to the next step. After the final step and a separate power-good delay, it raises the power-good output.

On the way down, the steps run in reverse and each step's rails are removed. Power-down starts when the input-voltage code falls below the turn-off threshold, when the enable input goes inactive, when an enabled rail loses its good status, or when the over-voltage flag is raised. The upstream input-power enable rises with the first step. At power-down it falls ahead of every rail when an over-voltage caused the shutdown, and after the whole reverse walk otherwise.

The analog measurement, the limit comparison, configuration storage and the host bus all sit outside this block. Their results arrive as codes, status bits and configuration vectors. Configurable XOR stages at the block's edge set the polarity of the enable input and of every output.

Top module: `rail_sequencer`

## Requirements
- R1: From idle, a power-up begins only when `vin_code` is strictly greater than `von_thr` and the enable is active (`en_in ^ en_inv` = 1). In the same clock, `inpwr_en` and the rails of step 1 turn on. A code equal to the threshold starts nothing.
- R2: Enable vector bit i (bits 3:0 drive `pol_en`, bits 5:4 drive `aux_en`) is switched by bit i of each step mask. Step k's mask is `step_mask[k*6 +: 6]` and its delay is `step_dly[k*16 +: 16]`, for k = 0..5. On the way up, the steps are ORed into the enabled set strictly in order 1 to 6, and each step waits its own delay before the next step is applied.
- R3: When a step's delay expires, every rail enabled so far must have its `pg_ok` bit set. Otherwise no further step is applied, and the sequencer powers down starting from the step that failed.
- R4: After step 6 passes its check, the sequencer waits `pg_dly` ticks and then asserts `pwr_good`.
- R5: Power-down is triggered by `vin_code` strictly below `voff_thr`, by the enable going inactive, by any enabled rail with `pg_ok` low, or by `ovp_flag`. A code equal to `voff_thr` keeps the rails on. The same conditions also abort a power-up that is still in progress.
- R6: `pwr_good` falls at least one clock before the first rail turns off. Power-down clears the rails of each step's mask from the current step back to step 1, and waits that step's delay after each one.
- R7: `inpwr_en` falls in the clock in which an over-voltage trigger is seen, before any rail turns off. Without an over-voltage trigger, it falls as the last change, after step 1's power-down delay.
- R8: Every delay is a 16-bit count of ticks of an internal strobe that fires once every `TICK_DIV` clocks. A delay of N therefore lasts between N-1 and N tick periods, plus a few clocks.
- R9: While a power-down is in progress, the start conditions are ignored. The power-down completes, and only then can a new power-up begin.
- R10: Output pin bit j equals internal state bit j XOR `out_inv[j]`. The internal state bits are: bits 5:0 the rail enables, bit 6 `inpwr_en`, bit 7 `pwr_good`.
- R11: After reset all rail enables, `inpwr_en` and `pwr_good` are inactive (pins equal to `out_inv`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vin_code | input | 12 | Sampled input-voltage code |
| von_thr | input | 12 | Turn-on threshold (start when code is above it) |
| voff_thr | input | 12 | Turn-off threshold (stop when code is below it) |
| en_in | input | 1 | Raw enable input |
| en_inv | input | 1 | Inverts the enable input when set |
| pg_ok | input | 6 | Per-rail within-limits status |
| ovp_flag | input | 1 | Over-voltage fault flag |
| step_mask | input | 36 | Six 6-bit rail masks, step 1 in the low bits |
| step_dly | input | 96 | Six 16-bit step delays in ticks |
| pg_dly | input | 16 | Power-good delay in ticks |
| out_inv | input | 8 | Output polarity: rails, input power, power good |
| pol_en | output | 4 | Converter enables |
| aux_en | output | 2 | Auxiliary enables |
| inpwr_en | output | 1 | Upstream input-power enable |
| pwr_good | output | 1 | System power good |

## Verification
The bench targets the strict threshold comparisons. A design that used a non-strict compare would start at a code equal to the turn-on threshold, or drop the rails at a code equal to the turn-off threshold. It also forces a rail fault at step 3 of a power-up while the start conditions stay true throughout. A wrong unwind would clear from step 1, continue to step 4, or restart before finishing. The over-voltage case and the plain shutdown together check the ordering of the input-power enable, which a design with a fixed ordering gets wrong in one of the two. The gaps between a late step and the next step, and between step 6 and power good, are measured against the tick bounds. This catches a delay that is skipped or that is charged to the wrong step.

// File: rtl/rseq_pkg.sv
// Shared types for the rail sequencer.
// Assumes: nothing beyond the state encoding being private to the block.
package rseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_UP_WAIT = 3'd1,
        ST_PG_WAIT = 3'd2,
        ST_ON      = 3'd3,
        ST_DN_CLR  = 3'd4,
        ST_DN_WAIT = 3'd5
    } seq_state_e;
endpackage

// File: rtl/rseq_tick.sv
// Free-running prescaler: emits a one-clock strobe every DIV clocks.
// Assumes: DIV >= 2; the strobe phase is not tied to any delay start.
module rseq_tick #(
    parameter int unsigned DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks and pulse the strobe when the count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CW'(1);
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/rseq_timer.sv
// Single shared down-counter for all step and power-good delays.
// Assumes: the owner reads done only in cycles after a load, never during it.
module rseq_timer #(
    parameter int unsigned DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             done
);
    logic [DLY_W-1:0] cnt_q;

    // Load a fresh delay, otherwise step down once per tick until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/rseq_polarity.sv
// Polarity stage at the block edge: XOR on the enable input and all outputs.
// Assumes: polarity settings are static while a sequence runs.
module rseq_polarity #(
    parameter int unsigned NOUT = 6
) (
    input  logic            en_raw,
    input  logic            en_inv,
    input  logic [NOUT-1:0] rails,
    input  logic            inpwr,
    input  logic            pg,
    input  logic [NOUT+1:0] out_inv,
    output logic            en_act,
    output logic [NOUT+1:0] out_pins
);
    assign en_act   = en_raw ^ en_inv;
    assign out_pins = {pg, inpwr, rails} ^ out_inv;
endmodule

// File: rtl/rseq_fsm.sv
// Sequencing state machine: ordered power-up with per-step good checks,
// reverse power-down, power-good delay and input-power enable ordering.
// Assumes: pg_ok and ovp_flag are already synchronous and qualified.
module rseq_fsm
    import rseq_pkg::*;
#(
    parameter int unsigned NOUT    = 6,
    parameter int unsigned N_STEPS = 6,
    parameter int unsigned DLY_W   = 16,
    parameter int unsigned VIN_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [VIN_W-1:0]         vin_code,
    input  logic [VIN_W-1:0]         von_thr,
    input  logic [VIN_W-1:0]         voff_thr,
    input  logic                     en_act,
    input  logic [NOUT-1:0]          pg_ok,
    input  logic                     ovp_flag,
    input  logic [N_STEPS*NOUT-1:0]  step_mask,
    input  logic [N_STEPS*DLY_W-1:0] step_dly,
    input  logic [DLY_W-1:0]         pg_dly,
    input  logic                     tmr_done,
    output logic                     tmr_load,
    output logic [DLY_W-1:0]         tmr_val,
    output logic [NOUT-1:0]          rails_q,
    output logic                     inpwr_q,
    output logic                     pg_q
);
    localparam int unsigned STEP_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
    localparam int unsigned NSLOT  = 1 << STEP_W;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

    logic [NOUT-1:0]  mask_a [NSLOT];
    logic [DLY_W-1:0] dly_a  [NSLOT];

    // Unpack the flat configuration vectors; unused slots read as zero.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s < N_STEPS) begin : g_used
            assign mask_a[s] = step_mask[s*NOUT +: NOUT];
            assign dly_a[s]  = step_dly[s*DLY_W +: DLY_W];
        end else begin : g_pad
            assign mask_a[s] = '0;
            assign dly_a[s]  = '0;
        end
    end

    seq_state_e       st_q, st_d;
    logic [STEP_W-1:0] step_q, step_d, step_nxt;
    logic [NOUT-1:0]  rails_d;
    logic             inpwr_d, pg_d;
    logic             start_ok, stop_req, fault;

    assign start_ok = (vin_code > von_thr) && en_act;
    assign stop_req = (vin_code < voff_thr) || !en_act || ovp_flag;
    assign fault    = |(rails_q & ~pg_ok);
    assign step_nxt = step_q + STEP_W'(1);

    // Next-state and action decode for every sequencing state.
    always_comb begin
        st_d     = st_q;
        step_d   = step_q;
        rails_d  = rails_q;
        inpwr_d  = inpwr_q;
        pg_d     = pg_q;
        tmr_load = 1'b0;
        tmr_val  = dly_a[step_q];
        case (st_q)
            ST_IDLE: begin
                rails_d = '0;
                inpwr_d = 1'b0;
                pg_d    = 1'b0;
                if (start_ok) begin
                    inpwr_d  = 1'b1;
                    rails_d  = mask_a[0];
                    step_d   = '0;
                    tmr_load = 1'b1;
                    tmr_val  = dly_a[0];
                    st_d     = ST_UP_WAIT;
                end
            end
            ST_UP_WAIT: begin
                if (stop_req) begin
                    if (ovp_flag) inpwr_d = 1'b0;
                    st_d = ST_DN_CLR;
                end else if (tmr_done) begin
                    if (fault) begin
                        st_d = ST_DN_CLR;
                    end else if (step_q == LAST_STEP) begin
                        tmr_load = 1'b1;
                        tmr_val  = pg_dly;
                        st_d     = ST_PG_WAIT;
                    end else begin
                        step_d   = step_nxt;
                        rails_d  = rails_q | mask_a[step_nxt];
                        tmr_load = 1'b1;
                        tmr_val  = dly_a[step_nxt];
                    end
                end
            end
            ST_PG_WAIT: begin
                if (stop_req || fault) begin
                    if (ovp_flag) inpwr_d = 1'b0;
                    st_d = ST_DN_CLR;
                end else if (tmr_done) begin
                    pg_d = 1'b1;
                    st_d = ST_ON;
                end
            end
            ST_ON: begin
                if (stop_req || fault) begin
                    pg_d = 1'b0;
                    if (ovp_flag) inpwr_d = 1'b0;
                    st_d = ST_DN_CLR;
                end
            end
            ST_DN_CLR: begin
                if (ovp_flag) inpwr_d = 1'b0;
                rails_d  = rails_q & ~mask_a[step_q];
                tmr_load = 1'b1;
                tmr_val  = dly_a[step_q];
                st_d     = ST_DN_WAIT;
            end
            ST_DN_WAIT: begin
                if (ovp_flag) inpwr_d = 1'b0;
                if (tmr_done) begin
                    if (step_q == '0) begin
                        inpwr_d = 1'b0;
                        rails_d = '0;
                        st_d    = ST_IDLE;
                    end else begin
                        step_d = step_q - STEP_W'(1);
                        st_d   = ST_DN_CLR;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            step_q  <= '0;
            rails_q <= '0;
            inpwr_q <= 1'b0;
            pg_q    <= 1'b0;
        end else begin
            st_q    <= st_d;
            step_q  <= step_d;
            rails_q <= rails_d;
            inpwr_q <= inpwr_d;
            pg_q    <= pg_d;
        end
    end
endmodule

// File: rtl/rail_sequencer.sv
// Top of the rail sequencer: prescaler, shared delay timer, sequencing
// state machine and edge polarity stage.
// Assumes: all inputs synchronous to clk; configuration stable while active.
module rail_sequencer #(
    parameter int unsigned N_RAIL   = 4,
    parameter int unsigned N_AUX    = 2,
    parameter int unsigned N_STEPS  = 6,
    parameter int unsigned DLY_W    = 16,
    parameter int unsigned VIN_W    = 12,
    parameter int unsigned TICK_DIV = 250000
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [VIN_W-1:0]                     vin_code,
    input  logic [VIN_W-1:0]                     von_thr,
    input  logic [VIN_W-1:0]                     voff_thr,
    input  logic                                 en_in,
    input  logic                                 en_inv,
    input  logic [N_RAIL+N_AUX-1:0]              pg_ok,
    input  logic                                 ovp_flag,
    input  logic [N_STEPS*(N_RAIL+N_AUX)-1:0]    step_mask,
    input  logic [N_STEPS*DLY_W-1:0]             step_dly,
    input  logic [DLY_W-1:0]                     pg_dly,
    input  logic [N_RAIL+N_AUX+1:0]              out_inv,
    output logic [N_RAIL-1:0]                    pol_en,
    output logic [N_AUX-1:0]                     aux_en,
    output logic                                 inpwr_en,
    output logic                                 pwr_good
);
    localparam int unsigned NOUT = N_RAIL + N_AUX;

    logic             tick, tmr_load, tmr_done, en_act;
    logic [DLY_W-1:0] tmr_val;
    logic [NOUT-1:0]  rails_q;
    logic             inpwr_q, pg_q;
    logic [NOUT+1:0]  out_pins;

    rseq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    rseq_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    rseq_fsm #(
        .NOUT   (NOUT),
        .N_STEPS(N_STEPS),
        .DLY_W  (DLY_W),
        .VIN_W  (VIN_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .vin_code (vin_code),
        .von_thr  (von_thr),
        .voff_thr (voff_thr),
        .en_act   (en_act),
        .pg_ok    (pg_ok),
        .ovp_flag (ovp_flag),
        .step_mask(step_mask),
        .step_dly (step_dly),
        .pg_dly   (pg_dly),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .rails_q  (rails_q),
        .inpwr_q  (inpwr_q),
        .pg_q     (pg_q)
    );

    rseq_polarity #(.NOUT(NOUT)) u_pol (
        .en_raw  (en_in),
        .en_inv  (en_inv),
        .rails   (rails_q),
        .inpwr   (inpwr_q),
        .pg      (pg_q),
        .out_inv (out_inv),
        .en_act  (en_act),
        .out_pins(out_pins)
    );

    assign pol_en   = out_pins[N_RAIL-1:0];
    assign aux_en   = out_pins[NOUT-1:N_RAIL];
    assign inpwr_en = out_pins[NOUT];
    assign pwr_good = out_pins[NOUT+1];
endmodule

// File: rtl/rail_sequencer_chk.sv
// Property checker for the rail sequencer, bound into the top module.
// Assumes: it observes the internal state before the polarity stage.
module rail_sequencer_chk #(
    parameter int unsigned NOUT  = 6,
    parameter int unsigned VIN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VIN_W-1:0] vin_code,
    input logic [VIN_W-1:0] von_thr,
    input logic             en_act,
    input logic [NOUT-1:0]  pg_ok,
    input logic             ovp_flag,
    input logic [NOUT-1:0]  rails,
    input logic             inpwr,
    input logic             pg
);
    logic ovp_seen;

    // Remember an over-voltage event until the block is fully off again.
    always_ff @(posedge clk) begin
        if (!rst_n) ovp_seen <= 1'b0;
        else if (!inpwr && (rails == '0)) ovp_seen <= 1'b0;
        else if (ovp_flag) ovp_seen <= 1'b1;
    end

    a_r11_reset_quiet: assert property (@(posedge clk)
        !$past(rst_n) |-> (rails == '0 && !inpwr && !pg));

    a_r1_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inpwr) |-> $past((vin_code > von_thr) && en_act));

    a_r4_pg_rise_healthy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg) |-> $past(~|(rails & ~pg_ok)));

    a_r6_pg_before_rails: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(rails) & ~rails)) |-> !$past(pg));

    a_r7_inpwr_last: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(inpwr) && !$past(ovp_seen) && !$past(ovp_flag)) |-> (rails == '0));

    a_r10_pg_needs_inpwr: assert property (@(posedge clk) disable iff (!rst_n)
        pg |-> inpwr);
endmodule

bind rail_sequencer rail_sequencer_chk #(.NOUT(NOUT), .VIN_W(VIN_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vin_code(vin_code),
    .von_thr (von_thr),
    .en_act  (en_act),
    .pg_ok   (pg_ok),
    .ovp_flag(ovp_flag),
    .rails   (rails_q),
    .inpwr   (inpwr_q),
    .pg      (pg_q)
);

// File: tb/rail_sequencer_tb.sv
`timescale 1ns/1ps
module rail_sequencer_tb;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] vin_code = 12'd0, von_thr = 12'd2000, voff_thr = 12'd1800;
    logic        en_in = 1'b0, en_inv = 1'b0, ovp_flag = 1'b0;
    logic [5:0]  pg_ok = 6'h3F;
    logic [35:0] step_mask;
    logic [95:0] step_dly;
    logic [15:0] pg_dly = 16'd10;
    logic [7:0]  out_inv = 8'h00;
    logic [3:0]  pol_en;
    logic [1:0]  aux_en;
    logic        inpwr_en, pwr_good;

    always #2 clk = ~clk;

    rail_sequencer #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .vin_code(vin_code), .von_thr(von_thr),
        .voff_thr(voff_thr), .en_in(en_in), .en_inv(en_inv), .pg_ok(pg_ok),
        .ovp_flag(ovp_flag), .step_mask(step_mask), .step_dly(step_dly),
        .pg_dly(pg_dly), .out_inv(out_inv), .pol_en(pol_en), .aux_en(aux_en),
        .inpwr_en(inpwr_en), .pwr_good(pwr_good)
    );

    wire [7:0] pins = {pwr_good, inpwr_en, aux_en, pol_en};
    wire [7:0] obs  = pins ^ out_inv;

    int          checks = 0, fails = 0;
    longint      cyc = 0;
    logic [7:0]  exp_q[$];
    longint      t_hist[$];
    logic [7:0]  mdl = 8'h00, last_obs = 8'h00, exp_v;
    bit          mon_on = 0, finished = 0;
    string       cur_req = "R11";

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] msk(input int k);
        return 8'(1 << k);
    endfunction

    // Driver side of the scoreboard: record a new expected output state.
    task automatic push(input logic [7:0] v);
        if (v != mdl) begin
            exp_q.push_back(v);
            mdl = v;
        end
    endtask

    task automatic exp_up_full();
        push(mdl | 8'h40 | msk(0));
        for (int k = 1; k < 6; k++) push(mdl | msk(k));
        push(mdl | 8'h80);
    endtask

    task automatic exp_down(input int from, input bit ovp);
        push(mdl & (ovp ? 8'h3F : 8'h7F));
        for (int k = from; k >= 0; k--) push(mdl & ~msk(k));
        push(mdl & 8'hBF);
    endtask

    task automatic drive_step();
        @(posedge clk);
        #1;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // Monitor side of the scoreboard: compare each output change.
    always @(negedge clk) begin
        cyc++;
        if (mon_on && obs !== last_obs) begin
            t_hist.push_back(cyc);
            if (exp_q.size() == 0) begin
                chk(0, {cur_req, " unexpected change"}, obs, last_obs);
            end else begin
                exp_v = exp_q.pop_front();
                chk(obs == exp_v, cur_req, obs, exp_v);
            end
            last_obs = obs;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 6; k++) begin
            step_mask[k*6 +: 6]  = 6'(1 << k);
            step_dly[k*16 +: 16] = 16'(k + 1);
        end
        repeat (5) drive_step();
        @(negedge clk);
        chk(pins == 8'h00, "R11 reset outputs", pins, 0);
        drive_step();
        rst_n = 1'b1;
        @(negedge clk);
        last_obs = obs;
        mon_on = 1;

        // R10: output polarity at idle
        cur_req = "R10";
        out_inv = 8'hFF;
        @(negedge clk);
        chk(pins == 8'hFF, "R10 inverted idle pins", pins, 8'hFF);
        drive_step();
        out_inv = 8'h00;

        // R1: code equal to the turn-on threshold must not start
        cur_req = "R1";
        vin_code = 12'd2000;
        en_in = 1'b1;
        repeat (50) @(negedge clk);
        chk(obs == 8'h00, "R1 no start at threshold", obs, 0);

        // R2 R4 R8: full power-up with timing
        cur_req = "R2";
        t_hist.delete();
        exp_up_full();
        drive_step();
        vin_code = 12'd2001;
        drain("R2 up order complete");
        chk(t_hist.size() == 7, "R2 change count", t_hist.size(), 7);
        if (t_hist.size() == 7) begin
            chk((t_hist[5] - t_hist[4]) >= 16 && (t_hist[5] - t_hist[4]) <= 22,
                "R8 step delay window", t_hist[5] - t_hist[4], 20);
            chk((t_hist[6] - t_hist[5]) >= 56 && (t_hist[6] - t_hist[5]) <= 70,
                "R4 pg delay window", t_hist[6] - t_hist[5], 64);
        end

        // R5: code equal to turn-off holds, one below shuts down
        cur_req = "R5";
        drive_step();
        vin_code = 12'd1800;
        repeat (40) @(negedge clk);
        chk(pwr_good == 1'b1, "R5 hold at turn-off threshold", pwr_good, 1);
        cur_req = "R6";
        exp_down(5, 0);
        drive_step();
        vin_code = 12'd1799;
        drain("R6 R7 down order after low input");
        drive_step();
        en_in = 1'b0;
        vin_code = 12'd2001;
        repeat (20) @(negedge clk);
        chk(obs == 8'h00, "R5 stays off", obs, 0);

        // R10: inverted enable input drives a full cycle
        cur_req = "R10";
        exp_up_full();
        drive_step();
        en_inv = 1'b1;
        drain("R10 up via inverted enable");
        chk(pwr_good == 1'b1, "R10 power good", pwr_good, 1);
        exp_down(5, 0);
        drive_step();
        en_in = 1'b1;
        drain("R10 down via inverted enable");
        drive_step();
        en_in = 1'b0;
        en_inv = 1'b0;

        // R3 R9: rail of step 3 never good; unwind with start held
        cur_req = "R3";
        drive_step();
        pg_ok = 6'b111011;
        push(mdl | 8'h40 | msk(0));
        push(mdl | msk(1));
        push(mdl | msk(2));
        push(mdl & ~msk(2));
        push(mdl & ~msk(1));
        push(mdl & ~msk(0));
        push(mdl & 8'hBF);
        drive_step();
        en_in = 1'b1;
        for (int i = 0; i < 3000 && exp_q.size() > 1; i++) @(negedge clk);
        chk(exp_q.size() == 1, "R9 down runs with start held", exp_q.size(), 1);
        drive_step();
        en_in = 1'b0;
        drain("R3 unwind from failing step");
        pg_ok = 6'h3F;

        // R5: good status lost while on
        cur_req = "R5";
        exp_up_full();
        drive_step();
        en_in = 1'b1;
        drain("R5 up before fault");
        exp_down(5, 0);
        drive_step();
        pg_ok = 6'b101111;
        for (int i = 0; i < 200 && pwr_good; i++) @(negedge clk);
        drive_step();
        en_in = 1'b0;
        drain("R5 R6 down after rail fault");
        pg_ok = 6'h3F;

        // R7: over-voltage drops input power first
        cur_req = "R7";
        exp_up_full();
        drive_step();
        en_in = 1'b1;
        drain("R7 up before over-voltage");
        push(mdl & 8'h3F);
        for (int k = 5; k >= 0; k--) push(mdl & ~msk(k));
        drive_step();
        ovp_flag = 1'b1;
        drive_step();
        ovp_flag = 1'b0;
        en_in = 1'b0;
        drain("R7 input power first");
        repeat (40) @(negedge clk);
        chk(obs == 8'h00, "R7 all off after over-voltage", obs, 0);

        // R5: abort during power-up unwinds from step 2
        cur_req = "R5";
        push(mdl | 8'h40 | msk(0));
        push(mdl | msk(1));
        push(mdl & ~msk(1));
        push(mdl & ~msk(0));
        push(mdl & 8'hBF);
        drive_step();
        en_in = 1'b1;
        for (int i = 0; i < 500 && !pol_en[1]; i++) @(negedge clk);
        drive_step();
        vin_code = 12'd1799;
        drain("R5 abort during power-up");
        drive_step();
        en_in = 1'b0;
        vin_code = 12'd2001;
        repeat (20) @(negedge clk);
        chk(obs == 8'h00, "R5 idle after abort", obs, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule